// File: doc/BRIEF.md
# Fixed-Priority Eight-Input Interrupt Controller

This block gathers eight interrupt request lines into one interrupt output for a processor on a byte-wide host bus. Each request is captured on its rising edge and held in a request register. A mask register blocks chosen inputs. An in-service register records which requests the host has taken and not yet closed. Input 0 has the highest priority and input 7 the lowest. A pending request raises the interrupt output only when it is unmasked and outranks every request already in service.

The host reaches the block through two addresses, selected by `a0`. A configuration sequence is written first. It starts with a command byte at the even address. One to three bytes at the odd address follow: the vector base, the cascade word and the mode word. The stored configuration is driven on output pins so that neighbouring logic can use it.

After configuration, odd-address accesses read and write the mask. Even-address writes are commands: poll, read-source selection and non-specific end of interrupt. A poll returns the winning request number on the next even-address read, and that read acknowledges the request. If the winning line has already gone low by then, the poll still returns a result, but nothing is placed in service.

Top module: `pic8_ctrl`

The configuration sequencer is a state machine with four states:
- `CFG_READY` is normal operation.
- `CFG_BASE` waits for the vector base.
- `CFG_CASC` waits for the cascade word.
- `CFG_MODE` waits for the mode word.

Its transitions are:
- Start: from any state to `CFG_BASE`, on an even write with bit 4 set.
- Base taken: from `CFG_BASE` to `CFG_CASC`, or straight to `CFG_MODE` or `CFG_READY` when the start byte requested single mode.
- Cascade taken: from `CFG_CASC` to `CFG_MODE`, or to `CFG_READY` when no mode word was requested.
- Mode taken: from `CFG_MODE` to `CFG_READY`.

## Requirements
- R1: After reset the mask reads 0xFF, the in-service and request registers read 0, `int_out` is low, and every configuration output is 0.
- R2: An even write with bit 4 set starts configuration. Bit 1 of that byte set to 0 means a cascade word follows, and bit 0 set to 1 means a mode word follows. The odd writes that follow load, in order, `cfg_vec_base`, then `cfg_cascade` and then bit 0 of the mode word into `cfg_cpu_mode`. `cfg_single` shows bit 1 of the start byte.
- R3: Starting configuration clears the in-service register and the mask, cancels a pending poll and selects the request register as the even-address read source. Requests already latched are kept.
- R4: In `CFG_READY`, an odd write loads the mask and an odd read returns it. A set mask bit stops that input from raising `int_out` or winning a poll, but its request still latches. Odd writes made during configuration leave the mask unchanged.
- R5: A rising edge on `irq_in[i]` sets request bit i one clock later. A line that stays high does not set the bit again. By default an even read returns the request register, and writing 0x0A selects it again.
- R6: Priority is fixed, with input 0 highest. `int_out` is high exactly when some unmasked latched request has a lower index than every set in-service bit.
- R7: Writing 0x0C arms a poll. The next even read returns 0x80 plus the winner's index, sets that in-service bit and clears that request bit. The poll then disarms, so later even reads return the selected register again.
- R8: A poll with no eligible request returns 0x07 and changes no register.
- R9: Writing 0x0B makes even reads return the in-service register. The selection survives polls and lasts until another selection byte (bit 3 set, bit 1 set) is written.
- R10: Writing 0x20 to the even address clears the in-service bit with the lowest index that is set. Writing it when no in-service bit is set does nothing.
- R11: If the poll winner's line is low at the acknowledging read, the read returns 0x87. The in-service register is left unchanged and the winner's latched request is cleared.
- R12: Command bytes written to the even address during configuration are ignored, apart from a new start byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Request lines, synchronous to clk, bit 0 highest priority |
| cs | input | 1 | Chip select, active high |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| a0 | input | 1 | Address select: 0 for the even (command) address, 1 for the odd (mask and configuration) address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address and read source |
| int_out | output | 1 | Interrupt request to the processor |
| cfg_vec_base | output | 8 | Stored vector base |
| cfg_cascade | output | 8 | Stored cascade word (slave mask on a master, identity on a slave) |
| cfg_single | output | 1 | Single-controller mode from the start byte |
| cfg_cpu_mode | output | 1 | Processor-mode bit from the mode word, 0 when no mode word was requested |

## Verification
The spurious case is the hardest to reach from the ports. It needs a request that is latched, wins arbitration and raises `int_out`, and whose line then falls before a poll is armed and read. The bench pulses a line for one cycle, confirms that `int_out` is high, then polls. It checks for 0x87, an empty in-service register and a cleared request register, and it does this on both the lowest-priority input and a middle one. Nested priority is reached by sweeping every ordered pair of inputs. The lower-priority request must be refused while the higher one is in service, and must win only after an end of interrupt.

// File: rtl/pic_pkg.sv
package pic_pkg;

    typedef enum logic [1:0] {
        CFG_READY,
        CFG_BASE,
        CFG_CASC,
        CFG_MODE
    } cfg_state_e;

    typedef enum logic {
        RSEL_IRR,
        RSEL_ISR
    } rd_sel_e;

    localparam logic [2:0] EOI_NS_TOP = 3'b001;

endpackage

// File: rtl/pic_cfg_seq.sv
module pic_cfg_seq
    import pic_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_cmd,
    input  logic          wr_port,
    input  logic [DW-1:0] wdata,
    output logic          init_start,
    output logic          busy,
    output logic [DW-1:0] vec_base,
    output logic [DW-1:0] cascade,
    output logic          single,
    output logic          cpu_mode
);

    cfg_state_e state_q, state_d;
    logic       need_mode_q;

    // Output process
    always_comb begin
        init_start = wr_cmd & wdata[4];
        busy       = (state_q != CFG_READY);
    end

    // Next-state process
    always_comb begin
        state_d = state_q;
        if (init_start) begin
            state_d = CFG_BASE;
        end else if (wr_port) begin
            unique case (state_q)
                CFG_READY: state_d = CFG_READY;
                CFG_BASE:  state_d = !single ? CFG_CASC
                                   : (need_mode_q ? CFG_MODE : CFG_READY);
                CFG_CASC:  state_d = need_mode_q ? CFG_MODE : CFG_READY;
                CFG_MODE:  state_d = CFG_READY;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CFG_READY;
        else        state_q <= state_d;
    end

    // Configuration storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_base    <= '0;
            cascade     <= '0;
            single      <= 1'b0;
            need_mode_q <= 1'b0;
            cpu_mode    <= 1'b0;
        end else if (init_start) begin
            single      <= wdata[1];
            need_mode_q <= wdata[0];
            cpu_mode    <= 1'b0;
        end else if (wr_port) begin
            if (state_q == CFG_BASE) vec_base <= wdata;
            if (state_q == CFG_CASC) cascade  <= wdata;
            if (state_q == CFG_MODE) cpu_mode <= wdata[0];
        end
    end

endmodule

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
    parameter int N  = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);

    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl
    import pic_pkg::*;
#(
    parameter int N_IN = 8,
    localparam int IW = $clog2(N_IN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] irq_in,
    input  logic            cs,
    input  logic            rd_en,
    input  logic            wr_en,
    input  logic            a0,
    input  logic [N_IN-1:0] wdata,
    output logic [N_IN-1:0] rdata,
    output logic            int_out,
    output logic [N_IN-1:0] cfg_vec_base,
    output logic [N_IN-1:0] cfg_cascade,
    output logic            cfg_single,
    output logic            cfg_cpu_mode
);

    logic            wr_even, wr_odd, rd_even;
    logic            init_start, cfg_busy;
    logic            cmd_sel, cmd_eoi, mask_wr, poll_rd;
    logic [N_IN-1:0] irr_q, isr_q, imr_q, prev_q;
    logic [N_IN-1:0] allowed, cand, rise, ack_clr, isr_set, isr_clr;
    logic [N_IN-1:0] poll_val;
    logic            poll_pend_q;
    rd_sel_e         rsel_q;
    logic            win_any, win_live, isr_any;
    logic [IW-1:0]   win_idx, isr_idx;

    assign wr_even = cs & wr_en & ~a0;
    assign wr_odd  = cs & wr_en &  a0;
    assign rd_even = cs & rd_en & ~a0;

    pic_cfg_seq #(.DW(N_IN)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_cmd     (wr_even),
        .wr_port    (wr_odd),
        .wdata      (wdata),
        .init_start (init_start),
        .busy       (cfg_busy),
        .vec_base   (cfg_vec_base),
        .cascade    (cfg_cascade),
        .single     (cfg_single),
        .cpu_mode   (cfg_cpu_mode)
    );

    // Command decode, accepted only while the sequencer is ready
    assign cmd_sel = wr_even & ~wdata[4] & wdata[3] & ~cfg_busy;
    assign cmd_eoi = wr_even & ~wdata[4] & ~wdata[3] & ~cfg_busy
                   & (wdata[7:5] == EOI_NS_TOP);
    assign mask_wr = wr_odd & ~cfg_busy;
    assign poll_rd = rd_even & poll_pend_q;

    // A request is eligible only above every in-service level
    always_comb begin
        logic acc;
        acc = 1'b0;
        for (int i = 0; i < N_IN; i++) begin
            acc        = acc | isr_q[i];
            allowed[i] = ~acc;
        end
    end

    assign cand = irr_q & ~imr_q & allowed;

    pic_prio_enc #(.N(N_IN)) win_enc_i (
        .req (cand),
        .any (win_any),
        .idx (win_idx)
    );

    pic_prio_enc #(.N(N_IN)) isr_enc_i (
        .req (isr_q),
        .any (isr_any),
        .idx (isr_idx)
    );

    assign win_live = irq_in[win_idx];
    assign int_out  = win_any;
    assign rise     = irq_in & ~prev_q;

    always_comb begin
        poll_val = '0;
        if (!win_any) begin
            poll_val[IW-1:0] = IW'(N_IN - 1);
        end else if (!win_live) begin
            poll_val[N_IN-1] = 1'b1;
            poll_val[IW-1:0] = IW'(N_IN - 1);
        end else begin
            poll_val[N_IN-1] = 1'b1;
            poll_val[IW-1:0] = win_idx;
        end
    end

    always_comb begin
        ack_clr = '0;
        isr_set = '0;
        isr_clr = '0;
        if (poll_rd && win_any) begin
            ack_clr[win_idx] = 1'b1;
            if (win_live) isr_set[win_idx] = 1'b1;
        end
        if (cmd_eoi && isr_any) isr_clr[isr_idx] = 1'b1;
    end

    always_comb begin
        if (a0)                    rdata = imr_q;
        else if (poll_pend_q)      rdata = poll_val;
        else if (rsel_q == RSEL_ISR) rdata = isr_q;
        else                       rdata = irr_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q      <= '1;
            irr_q       <= '0;
            isr_q       <= '0;
            imr_q       <= '1;
            rsel_q      <= RSEL_IRR;
            poll_pend_q <= 1'b0;
        end else begin
            prev_q <= irq_in;
            irr_q  <= (irr_q & ~ack_clr) | rise;
            if (init_start) begin
                isr_q       <= '0;
                imr_q       <= '0;
                rsel_q      <= RSEL_IRR;
                poll_pend_q <= 1'b0;
            end else begin
                isr_q <= (isr_q | isr_set) & ~isr_clr;
                if (mask_wr) imr_q <= wdata;
                if (cmd_sel && wdata[1]) rsel_q <= wdata[0] ? RSEL_ISR : RSEL_IRR;
                if (cmd_sel && wdata[2]) poll_pend_q <= 1'b1;
                else if (poll_rd)        poll_pend_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pic8_ctrl_chk.sv
module pic8_ctrl_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_even,
    input logic         wr_odd,
    input logic         rd_even,
    input logic [N-1:0] wdata,
    input logic         cfg_busy,
    input logic         poll_pend,
    input logic         win_any,
    input logic         win_live,
    input logic [N-1:0] irr,
    input logic [N-1:0] imr,
    input logic [N-1:0] isr,
    input logic         int_out
);

    // R4: mask takes the written byte in normal operation
    a_r4_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_odd && !cfg_busy) |=> (imr == $past(wdata)));

    // R3: starting configuration empties the mask and the in-service register
    a_r3_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_even && wdata[4]) |=> (imr == '0 && isr == '0));

    // R10: an end of interrupt removes exactly one in-service bit
    a_r10_eoi_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_even && wdata == 8'h20 && !cfg_busy && isr != '0 && !rd_even)
        |=> ($countones(isr) == $countones($past(isr)) - 1));

    // R7: in-service bits appear only on an acknowledging poll read, one at a time
    a_r7_isr_by_poll: assert property (@(posedge clk) disable iff (!rst_n)
        ((isr & ~$past(isr)) != '0) |-> $past(rd_even && poll_pend));

    a_r7_isr_one_new: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(isr & ~$past(isr)));

    // R6: the interrupt output needs an unmasked latched request
    a_r6_int_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ((irr & ~imr) != '0));

    // R11: a spurious acknowledge leaves the in-service register alone
    a_r11_spurious_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_even && poll_pend && win_any && !win_live) |=> (isr == $past(isr)));

endmodule

bind pic8_ctrl pic8_ctrl_chk #(.N(N_IN)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_even   (wr_even),
    .wr_odd    (wr_odd),
    .rd_even   (rd_even),
    .wdata     (wdata),
    .cfg_busy  (cfg_busy),
    .poll_pend (poll_pend_q),
    .win_any   (win_any),
    .win_live  (win_live),
    .irr       (irr_q),
    .imr       (imr_q),
    .isr       (isr_q),
    .int_out   (int_out)
);

// File: tb/pic8_ctrl_tb_top.sv
module pic8_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0;
    logic       cs = 1'b0, rd_en = 1'b0, wr_en = 1'b0, a0 = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       int_out;
    logic [7:0] cfg_vec_base, cfg_cascade;
    logic       cfg_single, cfg_cpu_mode;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pic8_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_in       (irq_in),
        .cs           (cs),
        .rd_en        (rd_en),
        .wr_en        (wr_en),
        .a0           (a0),
        .wdata        (wdata),
        .rdata        (rdata),
        .int_out      (int_out),
        .cfg_vec_base (cfg_vec_base),
        .cfg_cascade  (cfg_cascade),
        .cfg_single   (cfg_single),
        .cfg_cpu_mode (cfg_cpu_mode)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic adr, input logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; wr_en = 1'b1; a0 = adr; wdata = d;
        @(negedge clk);
        cs = 1'b0; wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic adr, output logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; rd_en = 1'b1; a0 = adr;
        #1 d = rdata;
        @(negedge clk);
        cs = 1'b0; rd_en = 1'b0;
    endtask

    task automatic std_init(input logic [7:0] casc);
        bus_wr(1'b0, 8'h11);
        bus_wr(1'b1, 8'h20);
        bus_wr(1'b1, casc);
        bus_wr(1'b1, 8'h01);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_rd(1'b1, r);  chk("R1 mask", r, 8'hFF);
        bus_rd(1'b0, r);  chk("R1 irr", r, 8'h00);
        bus_wr(1'b0, 8'h0B); bus_rd(1'b0, r); chk("R1 isr", r, 8'h00);
        chk("R1 int", {7'd0, int_out}, 8'h00);
        chk("R1 cfg", cfg_vec_base | cfg_cascade | {6'd0, cfg_single, cfg_cpu_mode}, 8'h00);

        // R2 / R3 full sequence
        std_init(8'h04);
        chk("R2 base", cfg_vec_base, 8'h20);
        chk("R2 casc", cfg_cascade, 8'h04);
        chk("R2 single", {7'd0, cfg_single}, 8'h00);
        chk("R2 mode", {7'd0, cfg_cpu_mode}, 8'h01);
        bus_rd(1'b1, r); chk("R3 mask cleared, R4 untouched by cfg", r, 8'h00);
        bus_rd(1'b0, r); chk("R3 irr selected", r, 8'h00);

        // R4 mask access
        bus_wr(1'b1, 8'hA5); bus_rd(1'b1, r); chk("R4 mask rw", r, 8'hA5);

        // R12 commands during configuration are ignored; single mode, no mode word
        bus_wr(1'b0, 8'h12);
        bus_wr(1'b0, 8'h0B);
        bus_wr(1'b1, 8'h48);
        bus_rd(1'b0, r); chk("R12 sel ignored", r, 8'h00);
        chk("R2 base single", cfg_vec_base, 8'h48);
        chk("R2 casc kept", cfg_cascade, 8'h04);
        chk("R2 mode cleared", {7'd0, cfg_cpu_mode}, 8'h00);
        chk("R2 single set", {7'd0, cfg_single}, 8'h01);
        bus_wr(1'b1, 8'h5A); bus_rd(1'b1, r); chk("R4 mask after short cfg", r, 8'h5A);

        // R2 single mode with mode word
        bus_wr(1'b0, 8'h13);
        bus_wr(1'b1, 8'h30);
        bus_wr(1'b1, 8'h01);
        chk("R2 base 13", cfg_vec_base, 8'h30);
        chk("R2 mode 13", {7'd0, cfg_cpu_mode}, 8'h01);
        bus_rd(1'b1, r); chk("R2 mask not loaded", r, 8'h00);

        // Slave-style cascade identity
        std_init(8'h02);
        chk("R2 slave id", cfg_cascade, 8'h02);

        // R8 empty poll
        bus_wr(1'b0, 8'h0C); bus_rd(1'b0, r); chk("R8 empty poll", r, 8'h07);

        // Single-input sweep: R5 R6 R7 R9 R10
        for (int i = 0; i < 8; i++) begin
            irq_in[i] = 1'b1;
            @(negedge clk);
            bus_rd(1'b0, r); chk("R5 latch", r, 8'(1 << i));
            chk("R6 int high", {7'd0, int_out}, 8'h01);
            bus_wr(1'b0, 8'h0C); bus_rd(1'b0, r); chk("R7 poll", r, 8'h80 | 8'(i));
            bus_rd(1'b0, r); chk("R5 no relatch while high, R7 cleared", r, 8'h00);
            chk("R6 int low in service", {7'd0, int_out}, 8'h00);
            irq_in[i] = 1'b0;
            bus_wr(1'b0, 8'h0B); bus_rd(1'b0, r); chk("R9 isr", r, 8'(1 << i));
            bus_wr(1'b0, 8'h0C); bus_rd(1'b0, r); chk("R8 poll blocked", r, 8'h07);
            bus_rd(1'b0, r); chk("R9 sel persists", r, 8'(1 << i));
            bus_wr(1'b0, 8'h20); bus_rd(1'b0, r); chk("R10 eoi", r, 8'h00);
            bus_wr(1'b0, 8'h20); bus_rd(1'b0, r); chk("R10 eoi empty", r, 8'h00);
            bus_wr(1'b0, 8'h0A);
        end

        // Pair sweep: R6 nesting, R10 lowest-index clear
        for (int i = 0; i < 8; i++) begin
            for (int j = i + 1; j < 8; j++) begin
                irq_in[i] = 1'b1; irq_in[j] = 1'b1;
                @(negedge clk);
                bus_wr(1'b0, 8'h0C); bus_rd(1'b0, r); chk("R6 pair high wins", r, 8'h80 | 8'(i));
                chk("R6 low blocked", {7'd0, int_out}, 8'h00);
                bus_wr(1'b0, 8'h20);
                chk("R6 low after eoi", {7'd0, int_out}, 8'h01);
                bus_wr(1'b0, 8'h0C); bus_rd(1'b0, r); chk("R7 pair second", r, 8'h80 | 8'(j));
                irq_in[i] = 1'b0; irq_in[j] = 1'b0;
                bus_wr(1'b0, 8'h20);
            end
        end

        // R6 higher request preempts a lower one in service; R10 order
        irq_in[5] = 1'b1; @(negedge clk);
        bus_wr(1'b0, 8'h0C); bus_rd(1'b0, r); chk("R7 poll 5", r, 8'h85);
        irq_in[2] = 1'b1; @(negedge clk);
        chk("R6 nested int", {7'd0, int_out}, 8'h01);
        bus_wr(1'b0, 8'h0C); bus_rd(1'b0, r); chk("R7 poll 2", r, 8'h82);
        bus_wr(1'b0, 8'h0B); bus_rd(1'b0, r); chk("R9 isr two", r, 8'h24);
        bus_wr(1'b0, 8'h20); bus_rd(1'b0, r); chk("R10 clears 2 first", r, 8'h20);
        bus_wr(1'b0, 8'h20); bus_rd(1'b0, r); chk("R10 clears 5", r, 8'h00);
        irq_in = '0;
        bus_wr(1'b0, 8'h0A);

        // Mask sweep: R4 R6
        for (int i = 0; i < 8; i++) begin
            bus_wr(1'b1, 8'(1 << i));
            irq_in[i] = 1'b1; @(negedge clk);
            chk("R4 masked int low", {7'd0, int_out}, 8'h00);
            bus_rd(1'b0, r); chk("R4 masked still latches", r, 8'(1 << i));
            bus_wr(1'b0, 8'h0C); bus_rd(1'b0, r); chk("R4 masked poll", r, 8'h07);
            bus_wr(1'b1, 8'h00);
            chk("R6 unmasked int", {7'd0, int_out}, 8'h01);
            bus_wr(1'b0, 8'h0C); bus_rd(1'b0, r); chk("R7 poll unmasked", r, 8'h80 | 8'(i));
            irq_in[i] = 1'b0;
            bus_wr(1'b0, 8'h20);
        end

        // R11 spurious on input 7 and input 4
        for (int k = 0; k < 2; k++) begin
            int s;
            s = (k == 0) ? 7 : 4;
            irq_in[s] = 1'b1; @(negedge clk);
            irq_in[s] = 1'b0; @(negedge clk);
            chk("R11 int latched", {7'd0, int_out}, 8'h01);
            bus_wr(1'b0, 8'h0C); bus_rd(1'b0, r); chk("R11 spurious code", r, 8'h87);
            bus_rd(1'b0, r); chk("R11 request dropped", r, 8'h00);
            bus_wr(1'b0, 8'h0B); bus_rd(1'b0, r); chk("R11 isr clear", r, 8'h00);
            bus_wr(1'b0, 8'h0A);
        end

        // R3 reconfiguration with work in flight
        irq_in[1] = 1'b1; @(negedge clk);
        bus_wr(1'b0, 8'h0C); bus_rd(1'b0, r); chk("R7 poll 1", r, 8'h81);
        irq_in[6] = 1'b1; @(negedge clk);
        bus_wr(1'b0, 8'h0B);
        bus_wr(1'b0, 8'h0C);
        std_init(8'h04);
        bus_rd(1'b0, r); chk("R3 irr kept, poll cancelled", r, 8'h40);
        bus_wr(1'b0, 8'h0B); bus_rd(1'b0, r); chk("R3 isr cleared", r, 8'h00);
        bus_rd(1'b1, r); chk("R3 mask cleared", r, 8'h00);
        irq_in = '0;

        finish_run();
    end

endmodule